// File: doc/BRIEF.md
# Asynchronous IO Write Fault Recorder

This block sits beside an IO bus master and watches each transaction it issues. A transaction opens with a start strobe that carries the address, a 3-bit size code, a read flag and a supervisor flag. It closes with an end strobe. Three kinds of asynchronous fault are recognised. A write that stays open for longer than a fixed limit is a timeout. A write that is answered with an error acknowledge is a bus error. A late-error pulse is a fault that the bus reports after a transaction, of either direction, has ended.

The first fault after a clear is recorded in a status word and a fault-address word, and software reads both through a simple select-and-read port. Faults that arrive while a record is held do not overwrite it. They only raise a multiple-fault indication. A single write strobe clears the record so that the next fault is captured fresh. The timeout limit is derived from the clock frequency and the limit in nanoseconds, which by default gives 640 cycles (12.8 µs at 50 MHz).

Top module: `async_fault_capture`

## Requirements
- R1: After reset, the status word (sel=0) reads 0x0080_0000 and the address word (sel=1) reads 0.
- R2: A write that receives no end strobe in the LIMIT cycles after its start edge sets status bit 29. An end strobe sampled within those LIMIT edges prevents this, and a read never times out. LIMIT = (CLK_HZ/1000)*TIMEOUT_NS/1e6.
- R3: An error acknowledge while a write is open sets status bit 28. An error acknowledge during a read transaction is ignored.
- R4: A late-error pulse sets status bit 30 for a read or a write, using the most recently started transaction.
- R5: Status bit 31 reads as the OR of bits 30, 29 and 28.
- R6: The first recorded fault loads the size code into bits 27:25, the supervisor flag into bit 24 and the read flag into bit 18. It also sets the address-valid bit 17 and loads the address word with the transaction address.
- R7: Bits 23:20 always read 4'h8, and every bit not named in these requirements reads 0.
- R8: A fault that arrives while any flag is held sets bit 19 and leaves every other field and the address word unchanged.
- R9: Two fault causes in the same cycle with no record held set both flag bits and do not set bit 19.
- R10: A clear strobe returns the status word to 0x0080_0000. The address word keeps its value, and the next fault is recorded as a first fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Transaction start strobe; samples address, size and flags |
| txn_end | input | 1 | Transaction end strobe |
| txn_addr | input | ADDR_W | Transaction address |
| txn_size | input | 3 | Transaction size code |
| txn_read | input | 1 | 1 = read transaction |
| txn_super | input | 1 | 1 = issued in supervisor mode |
| late_err | input | 1 | Late error reported by the bus |
| err_ack | input | 1 | Error acknowledge for the open transaction |
| clr_wr | input | 1 | Write-to-clear strobe for the status word |
| reg_sel | input | 1 | Read select: 0 status, 1 fault address |
| reg_rdata | output | 32 | Selected register contents (combinational) |

## Verification
Fault flags and captured fields become visible on the read port one edge after the cycle in which the cause is sampled. A timeout appears on the edge that falls LIMIT cycles after the start edge. The bench drives every strobe on a falling edge and releases it on the next falling edge, so each stimulus lands on exactly one rising edge. It reads the registers only at falling edges after the edge on which the result is due. The timeout sweep places the end strobe at every distance from 1 to LIMIT+3 cycles and waits beyond LIMIT before it reads, so both sides of the limit boundary are checked.

// File: rtl/async_fault_capture.sv
module async_fault_capture #(
  parameter int ADDR_W     = 32,
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_NS = 12_800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              txn_end,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [2:0]        txn_size,
  input  logic              txn_read,
  input  logic              txn_super,
  input  logic              late_err,
  input  logic              err_ack,
  input  logic              clr_wr,
  input  logic              reg_sel,
  output logic [31:0]       reg_rdata
);

  localparam int LIMIT_RAW = (CLK_HZ / 1000) * TIMEOUT_NS / 1_000_000;
  localparam int LIMIT     = (LIMIT_RAW < 1) ? 1 : LIMIT_RAW;
  localparam int CNT_W     = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);
  localparam logic [3:0] RSVD_VAL = 4'h8;

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] cur_addr;
  logic [2:0]        cur_size;
  logic              cur_rd, cur_sup;

  logic              le_q, to_q, be_q, me_q, rd_q, sup_q, fav_q;
  logic [2:0]        size_q;
  logic [ADDR_W-1:0] far_q;

  wire ev_to  = busy && !cur_rd && !txn_end && !txn_start && (cnt == CNT_LAST);
  wire ev_be  = err_ack && busy && !cur_rd;
  wire ev_le  = late_err;
  wire any_ev = ev_to || ev_be || ev_le;
  wire held   = (le_q || to_q || be_q) && !clr_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cur_addr <= '0;
      cur_size <= '0;
      cur_rd   <= 1'b0;
      cur_sup  <= 1'b0;
    end else if (txn_start) begin
      busy     <= 1'b1;
      cnt      <= '0;
      cur_addr <= txn_addr;
      cur_size <= txn_size;
      cur_rd   <= txn_read;
      cur_sup  <= txn_super;
    end else if (busy && (txn_end || ev_to)) begin
      busy <= 1'b0;
    end else if (busy && !cur_rd) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {le_q, to_q, be_q, me_q, rd_q, sup_q, fav_q} <= '0;
      size_q <= '0;
      far_q  <= '0;
    end else begin
      if (clr_wr) begin
        {le_q, to_q, be_q, me_q, rd_q, sup_q, fav_q} <= '0;
        size_q <= '0;
      end
      if (any_ev) begin
        if (held) begin
          me_q <= 1'b1;
        end else begin
          le_q   <= ev_le;
          to_q   <= ev_to;
          be_q   <= ev_be;
          me_q   <= 1'b0;
          size_q <= cur_size;
          sup_q  <= cur_sup;
          rd_q   <= cur_rd;
          fav_q  <= 1'b1;
          far_q  <= cur_addr;
        end
      end
    end
  end

  wire [31:0] status = {le_q | to_q | be_q, le_q, to_q, be_q, size_q, sup_q,
                        RSVD_VAL, me_q, rd_q, fav_q, 17'd0};

  assign reg_rdata = reg_sel ? 32'(far_q) : status;

  a_r8_record_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fav_q && !clr_wr) |=> ($stable(far_q) && $stable(size_q) && $stable(rd_q) && $stable(sup_q)));

  a_r8_me_needs_record: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(me_q) |-> $past(le_q || to_q || be_q));

  a_r6_fav_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fav_q |-> (le_q || to_q || be_q));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !late_err && !err_ack && !busy) |=> (!le_q && !to_q && !be_q && !me_q && !fav_q));

  a_r2_to_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> $past(busy && !cur_rd));

  a_r3_be_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(be_q) |-> $past(busy && !cur_rd && err_ack));

endmodule

// File: tb/test_async_fault_capture.sv
module test_async_fault_capture;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 16;
  localparam logic [31:0] IDLE = 32'h0080_0000;

  logic clk = 0, rst_n = 0;
  logic txn_start = 0, txn_end = 0, txn_read = 0, txn_super = 0;
  logic late_err = 0, err_ack = 0, clr_wr = 0, reg_sel = 0;
  logic [31:0] txn_addr = 0;
  logic [2:0]  txn_size = 0;
  logic [31:0] reg_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_fault_capture #(.ADDR_W(32), .CLK_HZ(1_250_000), .TIMEOUT_NS(12_800)) i_async_fault_capture (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_end(txn_end),
    .txn_addr(txn_addr), .txn_size(txn_size), .txn_read(txn_read),
    .txn_super(txn_super), .late_err(late_err), .err_ack(err_ack),
    .clr_wr(clr_wr), .reg_sel(reg_sel), .reg_rdata(reg_rdata));

  function automatic logic [31:0] exp_status(bit le, bit to, bit be, logic [2:0] sz,
                                             bit s, bit me, bit rd);
    return {le | to | be, le, to, be, sz, s, 4'h8, me, rd, 1'b1, 17'd0};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd_reg(bit sel, output logic [31:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start(logic [31:0] a, logic [2:0] sz, bit rd, bit s);
    txn_addr = a; txn_size = sz; txn_read = rd; txn_super = s; txn_start = 1;
    @(negedge clk); txn_start = 0;
  endtask

  task automatic pulse_end();   txn_end = 1;  @(negedge clk); txn_end = 0;  endtask
  task automatic pulse_late();  late_err = 1; @(negedge clk); late_err = 0; endtask
  task automatic pulse_ack();   err_ack = 1;  @(negedge clk); err_ack = 0;  endtask
  task automatic pulse_clr();   clr_wr = 1;   @(negedge clk); clr_wr = 0;   endtask

  initial begin
    #(CLK_PERIOD * 200_000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    tick(3); rst_n = 1; tick(1);

    rd_reg(0, v); check("R1 status reset", v, IDLE);
    rd_reg(1, v); check("R1 address reset", v, 32'd0);

    // R2 sweep: end strobe d cycles after start edge
    for (int d = 1; d <= LIMIT + 3; d++) begin
      for (int r = 0; r < 2; r++) begin
        logic [31:0] a;
        a = 32'h4000_0000 + 32'(d * 16 + r);
        start(a, 3'(d), bit'(r), bit'(d & 1));
        tick(d - 1); pulse_end(); tick(LIMIT + 2);
        rd_reg(0, v);
        if (r == 0 && d > LIMIT)
          check("R2 timeout status", v, exp_status(0, 1, 0, 3'(d), bit'(d & 1), 0, 0));
        else
          check("R2 no timeout", v, IDLE);
        rd_reg(1, v);
        if (r == 0 && d > LIMIT) check("R6 timeout address", v, a);
        pulse_clr();
      end
    end

    // R3 bus error on writes, all sizes and modes
    for (int k = 0; k < 16; k++) begin
      start(32'h1000_0000 + 32'(k), 3'(k), 0, bit'(k >> 3));
      tick(1); pulse_ack(); pulse_end(); tick(1);
      rd_reg(0, v); check("R3 bus error", v, exp_status(0, 0, 1, 3'(k), bit'(k >> 3), 0, 0));
      rd_reg(1, v); check("R6 bus error address", v, 32'h1000_0000 + 32'(k));
      pulse_clr();
      rd_reg(0, v); check("R10 cleared", v, IDLE);
      rd_reg(1, v); check("R10 address kept", v, 32'h1000_0000 + 32'(k));
    end

    // R3 error acknowledge on a read is ignored
    start(32'h2000_0000, 3'd2, 1, 0); pulse_ack(); pulse_end(); tick(1);
    rd_reg(0, v); check("R3 ack on read ignored", v, IDLE);

    // R4 late error after a read
    start(32'h2000_0040, 3'd5, 1, 1); pulse_end(); tick(2); pulse_late(); tick(1);
    rd_reg(0, v); check("R4 late error on read", v, exp_status(1, 0, 0, 3'd5, 1, 0, 1));
    rd_reg(1, v); check("R6 late error address", v, 32'h2000_0040);

    // R8 later fault sets only multiple bit
    start(32'h3000_0000, 3'd1, 0, 0); pulse_ack(); pulse_end(); tick(1);
    rd_reg(0, v); check("R8 multiple fault", v, exp_status(1, 0, 0, 3'd5, 1, 1, 1));
    rd_reg(1, v); check("R8 address unchanged", v, 32'h2000_0040);
    pulse_late(); tick(1);
    rd_reg(0, v); check("R8 multiple fault again", v, exp_status(1, 0, 0, 3'd5, 1, 1, 1));
    pulse_clr();
    rd_reg(0, v); check("R10 clears multiple", v, IDLE);

    // R9 same-cycle causes, R5 OR bit
    start(32'h5000_0000, 3'd3, 0, 1); tick(1);
    late_err = 1; err_ack = 1; @(negedge clk); late_err = 0; err_ack = 0;
    pulse_end(); tick(1);
    rd_reg(0, v); check("R9 two causes", v, exp_status(1, 0, 1, 3'd3, 1, 0, 0));
    check("R5 summary bit", {31'd0, v[31]}, 32'd1);
    pulse_clr();

    // R10 fault after clear is recorded fresh
    start(32'h6000_0000, 3'd7, 1, 0); pulse_end(); pulse_late(); tick(1);
    rd_reg(0, v); check("R10 fresh record", v, exp_status(1, 0, 0, 3'd7, 0, 0, 1));
    rd_reg(1, v); check("R10 fresh address", v, 32'h6000_0000);
    pulse_clr();
    rd_reg(0, v); check("R7 reserved field idle", v, IDLE);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule